// File: doc/BRIEF.md
# Pseudo-Grayscale Error Diffusion Processor

This block takes full-precision RGB pixels, 8 bits per channel at the default width, and reduces them to the 3, 4 or 6 bits per channel that a flat-panel column driver accepts. Each channel is handled on its own. The part of every pixel that truncation throws away is kept as an error term. Half of that error goes into the next pixel on the same line. The other half is parked in a line buffer and added back at the same column on the following line. A one-bit frame phase adds a small bias to the parked error on alternate frames, so the rounding pattern shifts from frame to frame and averages out when viewed.

Position is taken only from the active-low horizontal and vertical sync inputs. A column counter restarts at every horizontal sync falling edge, and the frame phase flips at every vertical sync falling edge. No resolution needs to be programmed. A pixel is active when both syncs are high. The reduced pixels and the sync signals leave the block exactly two dot clocks after they enter, and they stay aligned with each other. The line buffer is written so that block RAM can hold it. After reset the block clears the buffer with a sweep of one entry per clock.

Top module: `gray_diffuser`

## Requirements
- R1: While reset is applied, all data outputs are 0 and both sync outputs are 1. After reset the line buffer sweeps every entry to zero, one per clock over LINE_DEPTH clocks, so the first line reads zero stored error.
- R2: Mode encoding is 0 for 3 bits, 1 for 4 bits, and 2 or 3 for 6 bits. The code is right-aligned in each 6-bit output and the unused upper bits are 0.
- R3: For an active pixel, each channel forms sum = input + carry + stored term. The sum is clipped to 255. The output code is the clipped sum with its low (8 − width) bits dropped, and those dropped bits form the error e.
- R4: floor(e/2) becomes the carry for the next active pixel on the same line. The carry of every channel is zeroed by a horizontal sync falling edge.
- R5: e − floor(e/2) is written to the line buffer at the pixel's column and read back as the stored term at that column on the next line.
- R6: The column counter is reset to 0 by a horizontal sync falling edge. It advances by one for each active pixel (both syncs high) and stops at LINE_DEPTH.
- R7: A frame phase bit starts at 0 after reset and toggles on each vertical sync falling edge. While it is 1, the stored term of an in-range column is the buffer entry plus 1.
- R8: A pixel whose column is LINE_DEPTH or more gets a stored term of 0 and writes nothing to the line buffer. Only the carry still applies to it.
- R9: Data and both syncs appear at the outputs two clocks after they are sampled. Data is 0 whenever either delayed sync is low.
- R10: Inactive pixels leave the carry, the line buffer and the column counter unchanged, whatever data they carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Output depth select (0: 3 bits, 1: 4 bits, 2/3: 6 bits) |
| hsync_n_i | input | 1 | Horizontal sync, active low |
| vsync_n_i | input | 1 | Vertical sync, active low |
| red_i | input | IN_W | Red input level |
| green_i | input | IN_W | Green input level |
| blue_i | input | IN_W | Blue input level |
| red_o | output | 6 | Reduced red code, right-aligned |
| green_o | output | 6 | Reduced green code, right-aligned |
| blue_o | output | 6 | Reduced blue code, right-aligned |
| hsync_n_o | output | 1 | Horizontal sync delayed by two clocks |
| vsync_n_o | output | 1 | Vertical sync delayed by two clocks |

## Verification
The last pixel of a line is quantised, which updates its carry and writes its column, on the same clock edge that samples the horizontal sync falling edge and restarts the column count. In the same way, the last pixel of a frame is quantised on the edge that samples the vertical sync fall and flips the frame phase. The bench starts every line and every frame immediately after the final active pixel, with no idle gap, so both collisions happen. It judges them through the codes of the first pixels of the next line and the next frame, which depend on the stored terms, the cleared carry and the phase being exactly as the requirements predict.

// File: rtl/gd_pkg.sv
`timescale 1ns/1ps
package gd_pkg;
  // Output bus width per channel: the widest selectable depth.
  localparam int OUT_W = 6;

  typedef enum logic [1:0] {
    DEPTH_3 = 2'd0,
    DEPTH_4 = 2'd1,
    DEPTH_6 = 2'd2,
    DEPTH_6_ALT = 2'd3
  } depth_e;

  // Number of low input bits discarded for a given depth select.
  function automatic int unsigned drop_bits(input depth_e sel, input int unsigned in_w);
    case (sel)
      DEPTH_3: return in_w - 3;
      DEPTH_4: return in_w - 4;
      default: return in_w - 6;
    endcase
  endfunction
endpackage

// File: rtl/gd_sync_track.sv
`timescale 1ns/1ps
module gd_sync_track #(
  parameter int DEPTH = 1024,
  parameter int COL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_n,
  input  logic             vs_n,
  output logic [COL_W-1:0] col,
  output logic             hs_fall,
  output logic             active,
  output logic             phase
);
  logic hs_d, vs_d, ph_q;
  logic [COL_W-1:0] col_r;

  assign hs_fall = hs_d & ~hs_n;
  assign active  = hs_n & vs_n;
  assign col     = col_r;
  assign phase   = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d  <= 1'b1;
      vs_d  <= 1'b1;
      ph_q  <= 1'b0;
      col_r <= '0;
    end else begin
      hs_d <= hs_n;
      vs_d <= vs_n;
      if (vs_d && !vs_n) ph_q <= ~ph_q;
      if (hs_fall) col_r <= '0;
      else if (active && col_r != COL_W'(DEPTH)) col_r <= col_r + 1'b1;
    end
  end
endmodule

// File: rtl/gd_line_buf.sv
`timescale 1ns/1ps
module gd_line_buf #(
  parameter int DEPTH = 1024,
  parameter int DW    = 15,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sweep_addr;
  logic          sweep_on;

  assign busy = sweep_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweep_on   <= 1'b1;
      sweep_addr <= '0;
    end else if (sweep_on) begin
      sweep_addr <= sweep_addr + 1'b1;
      if (sweep_addr == AW'(DEPTH - 1)) sweep_on <= 1'b0;
    end
  end

  // Single write port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (sweep_on) mem[sweep_addr] <= '0;
    else if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/gd_quant.sv
`timescale 1ns/1ps
module gd_quant
  import gd_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ERR_W = IN_W - 3
) (
  input  logic [IN_W-1:0]  pix,
  input  logic [ERR_W-1:0] carry,
  input  logic [ERR_W-1:0] stored,
  input  logic             use_stored,
  input  logic             phase,
  input  logic [1:0]       mode,
  output logic [OUT_W-1:0] code,
  output logic [ERR_W-1:0] carry_nx,
  output logic [ERR_W-1:0] down
);
  localparam int SUM_W = IN_W + 2;
  localparam int MAXV  = (1 << IN_W) - 1;

  logic [SUM_W-1:0] sum, clip, mask, err, level;
  int unsigned sh;

  always_comb begin
    sh    = drop_bits(depth_e'(mode), IN_W);
    sum   = SUM_W'(pix) + SUM_W'(carry)
          + (use_stored ? SUM_W'(stored) + SUM_W'(phase) : '0);
    clip  = (sum > SUM_W'(MAXV)) ? SUM_W'(MAXV) : sum;
    mask  = (SUM_W'(1) << sh) - SUM_W'(1);
    err   = clip & mask;
    level = clip >> sh;
    code     = OUT_W'(level);
    carry_nx = ERR_W'(err >> 1);
    down     = ERR_W'(err - (err >> 1));
  end
endmodule

// File: rtl/gray_diffuser.sv
`timescale 1ns/1ps
module gray_diffuser
  import gd_pkg::*;
#(
  parameter int IN_W       = 8,
  parameter int LINE_DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             hsync_n_i,
  input  logic             vsync_n_i,
  input  logic [IN_W-1:0]  red_i,
  input  logic [IN_W-1:0]  green_i,
  input  logic [IN_W-1:0]  blue_i,
  output logic [OUT_W-1:0] red_o,
  output logic [OUT_W-1:0] green_o,
  output logic [OUT_W-1:0] blue_o,
  output logic             hsync_n_o,
  output logic             vsync_n_o
);
  localparam int NCH   = 3;
  localparam int ERR_W = IN_W - 3;
  localparam int COL_W = $clog2(LINE_DEPTH + 1);
  localparam int AW    = $clog2(LINE_DEPTH);
  localparam int LB_W  = NCH * ERR_W;

  logic [COL_W-1:0] col_q;
  logic             hs_fall, act, phase;
  logic             clr_busy, lb_we, lb_ok;
  logic [LB_W-1:0]  lb_rd, lb_wd;
  logic [NCH*IN_W-1:0]  pix_bus;
  logic [NCH*OUT_W-1:0] out_bus;

  // Stage 1 registers
  logic [NCH*IN_W-1:0] s1_pix;
  logic [COL_W-1:0]    s1_col;
  logic [1:0]          s1_mode;
  logic                s1_act, s1_hsfall, s1_lbok, s1_hs, s1_vs;

  assign pix_bus = {blue_i, green_i, red_i};
  assign lb_ok   = (col_q < COL_W'(LINE_DEPTH)) && !clr_busy;

  gd_sync_track #(.DEPTH(LINE_DEPTH), .COL_W(COL_W)) u_sync (
    .clk(clk), .rst(rst), .hs_n(hsync_n_i), .vs_n(vsync_n_i),
    .col(col_q), .hs_fall(hs_fall), .active(act), .phase(phase)
  );

  gd_line_buf #(.DEPTH(LINE_DEPTH), .DW(LB_W), .AW(AW)) u_lbuf (
    .clk(clk), .rst(rst),
    .rd_addr(AW'(col_q)), .rd_data(lb_rd),
    .wr_en(lb_we), .wr_addr(AW'(s1_col)), .wr_data(lb_wd),
    .busy(clr_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_pix    <= '0;
      s1_col    <= '0;
      s1_mode   <= '0;
      s1_act    <= 1'b0;
      s1_hsfall <= 1'b0;
      s1_lbok   <= 1'b0;
      s1_hs     <= 1'b1;
      s1_vs     <= 1'b1;
    end else begin
      s1_pix    <= pix_bus;
      s1_col    <= col_q;
      s1_mode   <= mode_i;
      s1_act    <= act;
      s1_hsfall <= hs_fall;
      s1_lbok   <= lb_ok;
      s1_hs     <= hsync_n_i;
      s1_vs     <= vsync_n_i;
    end
  end

  assign lb_we = s1_act && s1_lbok;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [ERR_W-1:0] carry_r, carry_nx, down;
    logic [OUT_W-1:0] code, out_r;

    gd_quant #(.IN_W(IN_W), .ERR_W(ERR_W)) u_quant (
      .pix(s1_pix[ch*IN_W +: IN_W]),
      .carry(carry_r),
      .stored(lb_rd[ch*ERR_W +: ERR_W]),
      .use_stored(s1_lbok),
      .phase(phase),
      .mode(s1_mode),
      .code(code),
      .carry_nx(carry_nx),
      .down(down)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        carry_r <= '0;
        out_r   <= '0;
      end else begin
        out_r <= s1_act ? code : '0;
        if (s1_hsfall) carry_r <= '0;
        else if (s1_act) carry_r <= carry_nx;
      end
    end

    assign lb_wd[ch*ERR_W +: ERR_W]   = down;
    assign out_bus[ch*OUT_W +: OUT_W] = out_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n_o <= 1'b1;
      vsync_n_o <= 1'b1;
    end else begin
      hsync_n_o <= s1_hs;
      vsync_n_o <= s1_vs;
    end
  end

  assign red_o   = out_bus[0*OUT_W +: OUT_W];
  assign green_o = out_bus[1*OUT_W +: OUT_W];
  assign blue_o  = out_bus[2*OUT_W +: OUT_W];
endmodule

// File: rtl/gd_checker.sv
`timescale 1ns/1ps
module gd_checker
  import gd_pkg::*;
#(
  parameter int LINE_DEPTH = 1024,
  parameter int COL_W      = $clog2(LINE_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_i,
  input logic             hsync_n_i,
  input logic             vsync_n_i,
  input logic             hsync_n_o,
  input logic             vsync_n_o,
  input logic [OUT_W-1:0] red_o,
  input logic [OUT_W-1:0] green_o,
  input logic [OUT_W-1:0] blue_o,
  input logic [COL_W-1:0] col_q,
  input logic [COL_W-1:0] s1_col,
  input logic             lb_we,
  input logic             clr_busy
);
  // Cycles since reset, saturating at 2, guards two-deep history checks.
  logic [1:0] live;
  always_ff @(posedge clk) begin
    if (rst) live <= 2'd0;
    else if (live != 2'd2) live <= live + 2'd1;
  end

  a_r9_hsync_delay: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd2) |-> (hsync_n_o == $past(hsync_n_i, 2)));

  a_r9_vsync_delay: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd2) |-> (vsync_n_o == $past(vsync_n_i, 2)));

  a_r9_blank_data: assert property (@(posedge clk) disable iff (rst)
    (!hsync_n_o || !vsync_n_o) |-> (red_o == '0 && green_o == '0 && blue_o == '0));

  a_r2_narrow_code: assert property (@(posedge clk) disable iff (rst)
    (live == 2'd2 && $past(mode_i, 2) == 2'd0) |->
      (red_o[OUT_W-1:3] == '0 && green_o[OUT_W-1:3] == '0 && blue_o[OUT_W-1:3] == '0));

  a_r6_col_restart: assert property (@(posedge clk) disable iff (rst)
    $fell(hsync_n_i) |=> (col_q == '0));

  a_r8_no_far_write: assert property (@(posedge clk) disable iff (rst)
    lb_we |-> (s1_col < COL_W'(LINE_DEPTH)));

  a_r1_sweep_owns_ram: assert property (@(posedge clk) disable iff (rst)
    clr_busy |-> !lb_we);
endmodule

bind gray_diffuser gd_checker #(.LINE_DEPTH(LINE_DEPTH), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .mode_i(mode_i),
  .hsync_n_i(hsync_n_i), .vsync_n_i(vsync_n_i),
  .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
  .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
  .col_q(col_q), .s1_col(s1_col), .lb_we(lb_we), .clr_busy(clr_busy)
);

// File: tb/gray_diffuser_tb.sv
`timescale 1ns/1ps
module gray_diffuser_tb;
  localparam int DEPTH = 8;
  localparam int NPIX  = 12;
  // Stimulus vectors {red, green, blue}; expected codes come from the model below.
  localparam logic [23:0] PIX [NPIX] = '{
    24'h1080FF, 24'h377FFE, 24'hFF0341, 24'h00C599,
    24'h5AFF12, 24'hE320FF, 24'h7B9C06, 24'hFEFEFE,
    24'h0111C8, 24'hA43D77, 24'h2FE9FF, 24'h6608B3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_i = 2'd2;
  logic hsync_n_i = 1'b0, vsync_n_i = 1'b1;
  logic [7:0] red_i = '0, green_i = '0, blue_i = '0;
  logic [5:0] red_o, green_o, blue_o;
  logic hsync_n_o, vsync_n_o;

  always #2.5 clk = ~clk;

  gray_diffuser #(.IN_W(8), .LINE_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .mode_i(mode_i),
    .hsync_n_i(hsync_n_i), .vsync_n_i(vsync_n_i),
    .red_i(red_i), .green_i(green_i), .blue_i(blue_i),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o)
  );

  int total = 0, bad = 0;

  // Reference model state
  int lb [DEPTH][3];
  int carry [3];
  int col = 0;
  bit phase = 1'b0, prev_hs = 1'b1, prev_vs = 1'b1;

  // Two-deep expectation pipeline
  int e1_c [3], e2_c [3];
  bit e1_hs = 1'b1, e1_vs = 1'b1, e2_hs = 1'b1, e2_vs = 1'b1;
  string e1_tag = "R1 R9", e2_tag = "R1 R9";

  task automatic check_outputs();
    total++;
    if (red_o != 6'(e2_c[0]) || green_o != 6'(e2_c[1]) || blue_o != 6'(e2_c[2])) begin
      bad++;
      $display("FAIL %s data: got %0d/%0d/%0d expected %0d/%0d/%0d",
               e2_tag, red_o, green_o, blue_o, e2_c[0], e2_c[1], e2_c[2]);
    end
    total++;
    if (hsync_n_o != e2_hs || vsync_n_o != e2_vs) begin
      bad++;
      $display("FAIL R9 sync: got h=%0b v=%0b expected h=%0b v=%0b",
               hsync_n_o, vsync_n_o, e2_hs, e2_vs);
    end
  endtask

  // Check the output due now, drive one pixel, model it, advance one clock.
  task automatic step(input bit hs, input bit vs, input int idx, input bit [1:0] m);
    int px [3];
    int nc [3];
    int drop;
    bit inr;
    string tag;
    check_outputs();
    px[0] = int'(PIX[idx % NPIX][23:16]);
    px[1] = int'(PIX[idx % NPIX][15:8]);
    px[2] = int'(PIX[idx % NPIX][7:0]);
    hsync_n_i = hs; vsync_n_i = vs; mode_i = m;
    red_i = 8'(px[0]); green_i = 8'(px[1]); blue_i = 8'(px[2]);
    drop = (m == 2'd0) ? 5 : (m == 2'd1) ? 4 : 2;
    if (prev_hs && !hs) begin
      col = 0;
      for (int c = 0; c < 3; c++) carry[c] = 0;
    end
    if (prev_vs && !vs) phase = ~phase;
    prev_hs = hs; prev_vs = vs;
    tag = "R9 R10";
    for (int c = 0; c < 3; c++) nc[c] = 0;
    if (hs && vs) begin
      inr = (col < DEPTH);
      tag = "R2 R3 R4 R5 R6";
      if (inr && phase) tag = {tag, " R7"};
      if (!inr) tag = {tag, " R8"};
      for (int c = 0; c < 3; c++) begin
        int s, e;
        s = px[c] + carry[c] + (inr ? lb[col][c] + int'(phase) : 0);
        if (s > 255) s = 255;
        nc[c] = s >> drop;
        e = s % (1 << drop);
        carry[c] = e / 2;
        if (inr) lb[col][c] = e - e / 2;
      end
      if (col < DEPTH) col++;
    end
    e2_c = e1_c; e2_hs = e1_hs; e2_vs = e1_vs; e2_tag = e1_tag;
    e1_c = nc; e1_hs = hs; e1_vs = vs; e1_tag = tag;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int k;
    int w;
    bit [1:0] m;
    for (int i = 0; i < DEPTH; i++) for (int c = 0; c < 3; c++) lb[i][c] = 0;
    for (int c = 0; c < 3; c++) begin carry[c] = 0; e1_c[c] = 0; e2_c[c] = 0; end
    red_i = 8'hAA; green_i = 8'h55; blue_i = 8'hFF;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    total++;
    if (red_o != 0 || green_o != 0 || blue_o != 0 || !hsync_n_o || !vsync_n_o) begin
      bad++;
      $display("FAIL R1 reset: got %0d/%0d/%0d h=%0b v=%0b expected 0/0/0 h=1 v=1",
               red_o, green_o, blue_o, hsync_n_o, vsync_n_o);
    end
    rst = 1'b0;
    // Hold a blanked line with busy data while the buffer sweep runs (R1, R10).
    for (int i = 0; i < DEPTH + 4; i++) step(1'b0, 1'b1, i, 2'd2);
    k = 0;
    for (int f = 0; f < 4; f++) begin
      m = (f == 0) ? 2'd2 : (f == 1) ? 2'd1 : (f == 2) ? 2'd0 : 2'd3;
      // Frame start right after the previous active pixel (R7).
      step(1'b1, 1'b0, k + 3, m);
      step(1'b1, 1'b0, k + 5, m);
      for (int ln = 0; ln < 3; ln++) begin
        w = (f == 3 && ln == 2) ? DEPTH + 3 : 6;
        // Line start right after the last active pixel (R4, R6).
        step(1'b0, 1'b1, k + 7, m);
        step(1'b0, 1'b1, k + 1, m);
        for (int p = 0; p < w; p++) begin
          step(1'b1, 1'b1, k, m);
          k++;
        end
      end
    end
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, i, 2'd2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule